// File: doc/BRIEF.md
# Parallel Weight Update Engine

This block performs the per-pattern (stochastic) weight update step of backpropagation training. It handles one neuron at a time. A job begins with a single-cycle `start` that carries a learning rate, a choice between the hidden-layer and the output-layer gradient, a base address and a word count. From the learning rate and the chosen gradient the block first forms a scaled step. It then walks the neuron's weight words, each holding `LANES` signed fixed-point weights. For every weight it adds the product of the matching input and the step.

Weights sit in one external synchronous memory with a single port. For each word the block reads it in one cycle and writes the updated word back to the same address in the next. The port therefore alternates read, write, read, write with no idle cycles until the job ends. The input vector comes from a second synchronous store that is indexed by word number and read in the same cycle as the weights. All lanes work in lockstep, so one whole word is updated per read/write pair. A one-cycle `done` pulse follows the last write.

Top module: `weight_update_engine`

## Requirements
- R1: Values are signed two's complement with `FRAC` (default 8) fractional bits, and lane i sits at bits [DW*i+DW-1 : DW*i] of each word. The step is sat((lr*g) >>> FRAC). Each new weight is sat(w + sat((x*step) >>> FRAC)), where `>>>` is an arithmetic (floor) shift and sat clamps to the DW-bit range.
- R2: All lanes of a word are written together in one write cycle, and each lane uses only its own input and old weight.
- R3: Every intermediate and final result that leaves the DW-bit range is clamped to its maximum (0x7FFF) or minimum (0x8000) and never wraps.
- R4: When a job with N>0 words is accepted, the first read (mem_en=1, mem_we=0) is issued in the next cycle. Reads and writes (mem_en=1, mem_we=1) then alternate on consecutive cycles, word k at address base+k modulo 2^AW, for 2N cycles in all. Words outside that range are not touched.
- R5: Every write goes to the address of the read in the cycle before it. During the read of word k, x_addr equals k.
- R6: layer_sel=1 selects grad_out and layer_sel=0 selects grad_hid. The selection, the learning rate and the address fields are sampled only in the cycle `start` is accepted.
- R7: `done` is high for exactly one cycle, the cycle after the last write. busy and mem_en are low in that cycle.
- R8: `start` is ignored while busy or done is high. The running job's addresses and results are unchanged.
- R9: A job with word_cnt=0 makes no memory access and pulses done in the cycle after start is accepted.
- R10: During and after reset, busy, done and mem_en are low until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job request, accepted when idle |
| layer_sel | input | 1 | 1: output-layer gradient, 0: hidden-layer gradient |
| lr | input | DW | Learning rate, signed fixed point |
| grad_hid | input | DW | Gradient of the neuron from hidden-error storage |
| grad_out | input | DW | Gradient of the neuron from output-error storage |
| base_addr | input | AW | Address of the neuron's first weight word |
| word_cnt | input | CW | Number of weight words to update |
| busy | output | 1 | High while reads or writes are in progress |
| done | output | 1 | One-cycle pulse after the last write |
| mem_en | output | 1 | Weight memory access enable |
| mem_we | output | 1 | Weight memory write enable (read when low) |
| mem_addr | output | AW | Weight memory address |
| mem_wdata | output | LANES*DW | New weight word, valid in write cycles |
| mem_rdata | input | LANES*DW | Old weight word, one cycle after the read |
| x_addr | output | CW | Input-vector word index, valid in read cycles |
| x_rdata | input | LANES*DW | Input-vector word, one cycle after x_addr |

## Verification
Counting from the rising edge that accepts `start`, the read of word k is on the port 2k+1 cycles later. Its write, with the new word already on mem_wdata, follows 2k+2 cycles later. `done` follows 2N+1 cycles later, and 1 cycle later for an empty job. The bench drives inputs on falling edges and walks the job cycle by cycle from the accepting edge. It samples the port on each following falling edge against these counts, so every read, write and done pulse is checked in the exact cycle it is due. After each job, the bench memory model is compared word by word with values computed arithmetically from a snapshot. A sweep of learning-rate and gradient pairs, with word contents that include both range limits, reaches the clamps.

// File: rtl/wu_pkg.sv
package wu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } wu_state_e;

  // clamp a wide signed value to a w-bit signed range
  function automatic logic signed [31:0] sat_to(input logic signed [63:0] v,
                                                input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi[31:0];
    if (v < lo) return lo[31:0];
    return v[31:0];
  endfunction

  // fixed-point product: floor shift by frac, then clamp to w bits
  function automatic logic signed [31:0] q_mul(input logic signed [31:0] a,
                                               input logic signed [31:0] b,
                                               input int unsigned frac,
                                               input int unsigned w);
    logic signed [63:0] ae;
    logic signed [63:0] be;
    logic signed [63:0] p;
    ae = {{32{a[31]}}, a};
    be = {{32{b[31]}}, b};
    p  = ae * be;
    return sat_to(p >>> frac, w);
  endfunction

endpackage

// File: rtl/wu_lane.sv
module wu_lane #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic [DW-1:0] step,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] w_old,
  output logic [DW-1:0] w_new
);
  localparam int EXT = 32 - DW;

  logic signed [31:0] delta;
  logic signed [63:0] wide_sum;
  logic signed [31:0] clamped;

  always_comb begin
    delta    = wu_pkg::q_mul({{EXT{step[DW-1]}}, step}, {{EXT{x[DW-1]}}, x}, FRAC, DW);
    wide_sum = {{32{delta[31]}}, delta} + {{(64-DW){w_old[DW-1]}}, w_old};
    clamped  = wu_pkg::sat_to(wide_sum, DW);
    w_new    = clamped[DW-1:0];
  end
endmodule

// File: rtl/wu_gain.sv
module wu_gain #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          sel_out,
  input  logic [DW-1:0] lr,
  input  logic [DW-1:0] g_hid,
  input  logic [DW-1:0] g_out,
  output logic [DW-1:0] step_q
);
  localparam int EXT = 32 - DW;

  logic [DW-1:0]      grad_pick;
  logic signed [31:0] step_d;

  always_comb begin
    grad_pick = sel_out ? g_out : g_hid;
    step_d    = wu_pkg::q_mul({{EXT{lr[DW-1]}}, lr},
                              {{EXT{grad_pick[DW-1]}}, grad_pick}, FRAC, DW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    step_q <= '0;
    else if (load) step_q <= step_d[DW-1:0];
  end
endmodule

// File: rtl/wu_seq.sv
module wu_seq
  import wu_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] word_cnt,
  output logic          load,
  output logic          rd_slot,
  output logic          wr_slot,
  output logic          fin_slot,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] x_idx
);
  wu_state_e     st;
  logic [AW-1:0] base_q;
  logic [AW-1:0] wr_addr_q;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] idx_q;
  logic          last_word;

  assign load      = (st == ST_IDLE) && start;
  assign rd_slot   = (st == ST_RD);
  assign wr_slot   = (st == ST_WR);
  assign fin_slot  = (st == ST_FIN);
  assign rd_addr   = base_q + AW'(idx_q);
  assign last_word = (idx_q == cnt_q - CW'(1));
  assign addr      = wr_slot ? wr_addr_q : (rd_slot ? rd_addr : '0);
  assign x_idx     = rd_slot ? idx_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      base_q    <= '0;
      wr_addr_q <= '0;
      cnt_q     <= '0;
      idx_q     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          base_q <= base_addr;
          cnt_q  <= word_cnt;
          idx_q  <= '0;
          st     <= (word_cnt == '0) ? ST_FIN : ST_RD;
        end
        ST_RD: begin
          wr_addr_q <= rd_addr;
          st        <= ST_WR;
        end
        ST_WR: begin
          if (last_word) st <= ST_FIN;
          else begin
            idx_q <= idx_q + CW'(1);
            st    <= ST_RD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: the write slot reuses the address read one cycle before
  assert_write_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_slot |-> (addr == $past(addr)));
endmodule

// File: rtl/weight_update_engine.sv
module weight_update_engine #(
  parameter int LANES = 12,
  parameter int DW    = 16,
  parameter int FRAC  = 8,
  parameter int AW    = 10,
  parameter int CW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                layer_sel,
  input  logic [DW-1:0]       lr,
  input  logic [DW-1:0]       grad_hid,
  input  logic [DW-1:0]       grad_out,
  input  logic [AW-1:0]       base_addr,
  input  logic [CW-1:0]       word_cnt,
  output logic                busy,
  output logic                done,
  output logic                mem_en,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [LANES*DW-1:0] mem_wdata,
  input  logic [LANES*DW-1:0] mem_rdata,
  output logic [CW-1:0]       x_addr,
  input  logic [LANES*DW-1:0] x_rdata
);
  localparam int WORD_W = LANES * DW;

  logic              load;
  logic              rd_slot;
  logic              wr_slot;
  logic              fin_slot;
  logic [DW-1:0]     step_q;
  logic [WORD_W-1:0] lane_out;

  wu_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base_addr(base_addr), .word_cnt(word_cnt),
    .load(load), .rd_slot(rd_slot), .wr_slot(wr_slot), .fin_slot(fin_slot),
    .addr(mem_addr), .x_idx(x_addr)
  );

  wu_gain #(.DW(DW), .FRAC(FRAC)) u_gain (
    .clk(clk), .rst_n(rst_n), .load(load), .sel_out(layer_sel),
    .lr(lr), .g_hid(grad_hid), .g_out(grad_out), .step_q(step_q)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wu_lane #(.DW(DW), .FRAC(FRAC)) u_lane (
      .step(step_q),
      .x(x_rdata[i*DW +: DW]),
      .w_old(mem_rdata[i*DW +: DW]),
      .w_new(lane_out[i*DW +: DW])
    );
  end

  assign busy      = rd_slot | wr_slot;
  assign done      = fin_slot;
  assign mem_en    = rd_slot | wr_slot;
  assign mem_we    = wr_slot;
  assign mem_wdata = wr_slot ? lane_out : '0;

  // R4: every read is followed at once by a write
  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (mem_en && mem_we));
  // R4: no two writes in a row
  assert_no_double_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> !(mem_en && mem_we));
  // R7: done is quiet and lasts one cycle
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_en));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1: a zero step leaves every lane unchanged
  assert_zero_step_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && step_q == '0) |-> (mem_wdata == mem_rdata));
  // R8: step stays fixed while a job runs
  assert_step_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(step_q));
endmodule

// File: tb/tb_weight_update_engine.sv
module tb_weight_update_engine;
  localparam int LANES = 4;
  localparam int DW    = 16;
  localparam int FRAC  = 8;
  localparam int AW    = 6;
  localparam int CW    = 4;
  localparam int WW    = LANES * DW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          layer_sel = 1'b0;
  logic [DW-1:0] lr = '0;
  logic [DW-1:0] grad_hid = '0;
  logic [DW-1:0] grad_out = '0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] word_cnt = '0;
  logic          busy, done, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata;
  logic [WW-1:0] mem_rdata = '0;
  logic [CW-1:0] x_addr;
  logic [WW-1:0] x_rdata = '0;

  logic [WW-1:0] wmem [0:DEPTH-1];
  logic [WW-1:0] xmem [0:(1<<CW)-1];
  logic [WW-1:0] snap [0:DEPTH-1];

  int total = 0;
  int fails = 0;

  weight_update_engine #(.LANES(LANES), .DW(DW), .FRAC(FRAC), .AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .layer_sel(layer_sel), .lr(lr),
    .grad_hid(grad_hid), .grad_out(grad_out), .base_addr(base_addr),
    .word_cnt(word_cnt), .busy(busy), .done(done), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .x_addr(x_addr), .x_rdata(x_rdata)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) wmem[mem_addr] <= mem_wdata;
      else begin
        mem_rdata <= wmem[mem_addr];
        x_rdata   <= xmem[x_addr];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint clampw(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint qscale(longint a, longint b);
    longint p;
    longint r;
    p = a * b;
    r = p % 256;
    if (r < 0) r += 256;
    return clampw((p - r) / 256);
  endfunction

  function automatic longint lane_of(logic [WW-1:0] w, int i);
    logic [15:0] v;
    v = w[i*16 +: 16];
    return v[15] ? longint'(v) - 65536 : longint'(v);
  endfunction

  function automatic logic [WW-1:0] ref_word(logic [WW-1:0] w, logic [WW-1:0] x, longint st);
    logic [WW-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      longint nv;
      nv = clampw(lane_of(w, i) + qscale(lane_of(x, i), st));
      r[i*16 +: 16] = nv[15:0];
    end
    return r;
  endfunction

  function automatic longint vpick(int j);
    case (j % 8)
      0: return -32768;
      1: return -300;
      2: return -1;
      3: return 0;
      4: return 1;
      5: return 77;
      6: return 256;
      default: return 32767;
    endcase
  endfunction

  task automatic run_job(input int base, input int n, input bit sel, input longint lrv,
                         input longint gh, input longint go, input bit poke);
    longint st;
    logic [WW-1:0] expw;
    for (int a = 0; a < DEPTH; a++) snap[a] = wmem[a];
    st = qscale(lrv, sel ? go : gh);
    @(negedge clk);
    start = 1'b1; layer_sel = sel; lr = lrv[15:0];
    grad_hid = gh[15:0]; grad_out = go[15:0];
    base_addr = base[AW-1:0]; word_cnt = n[CW-1:0];
    @(negedge clk);
    if (poke) begin
      layer_sel = ~sel; lr = 16'h3039; grad_hid = 16'h7000; grad_out = 16'h9000;
      base_addr = 6'd63; word_cnt = 4'd15;
    end else start = 1'b0;
    if (n == 0) begin
      chk(done === 1'b1, "R9", "done after empty job", done, 1);
      chk(mem_en === 1'b0 && busy === 1'b0, "R9", "no access on empty job", mem_en, 0);
    end
    for (int k = 0; k < n; k++) begin
      chk(mem_en === 1'b1 && mem_we === 1'b0 && busy === 1'b1, "R4", "read slot",
          {mem_en, mem_we, busy}, 3'b101);
      chk(mem_addr === AW'(base + k), "R4", "read address", mem_addr, AW'(base + k));
      chk(x_addr === CW'(k), "R5", "input index", x_addr, k);
      @(negedge clk);
      chk(mem_en === 1'b1 && mem_we === 1'b1, "R4", "write slot", {mem_en, mem_we}, 2'b11);
      chk(mem_addr === AW'(base + k), "R5", "write address", mem_addr, AW'(base + k));
      expw = ref_word(snap[AW'(base + k)], xmem[k], st);
      chk(mem_wdata === expw, poke ? "R8 R2" : (sel ? "R1 R2 R6" : "R1 R3 R6"),
          "write word", mem_wdata, expw);
      if (poke) start = 1'b0;
      @(negedge clk);
    end
    if (n != 0) chk(done === 1'b1 && busy === 1'b0 && mem_en === 1'b0, "R7",
                    "done after last write", {done, busy, mem_en}, 3'b100);
    start = 1'b0;
    @(negedge clk);
    chk(done === 1'b0, n == 0 ? "R9" : "R7", "done single pulse", done, 0);
    for (int a = 0; a < DEPTH; a++) begin
      int off;
      off = (a - base + DEPTH) % DEPTH;
      expw = (off < n) ? ref_word(snap[a], xmem[off], st) : snap[a];
      chk(wmem[a] === expw, (off < n) ? "R1 R3" : "R4", "memory word", wmem[a], expw);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++)
      for (int i = 0; i < LANES; i++) begin
        longint v;
        v = vpick(a * 3 + i);
        wmem[a][i*16 +: 16] = v[15:0];
      end
    for (int k = 0; k < (1 << CW); k++)
      for (int i = 0; i < LANES; i++) begin
        longint v;
        v = vpick(k + i * 5);
        xmem[k][i*16 +: 16] = v[15:0];
      end
    // R10: reset state
    start = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_en === 1'b0, "R10", "during reset",
        {busy, done, mem_en}, 0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_en === 1'b0, "R10", "after reset",
        {busy, done, mem_en}, 0);

    run_job(0, 8, 1'b1, 128, -5000, 256, 1'b0);      // R1 R6 output gradient
    run_job(20, 5, 1'b0, 200, 700, -32768, 1'b0);    // R6 hidden gradient
    run_job(10, 3, 1'b1, 100, 1, 900, 1'b1);         // R8 start held while busy
    run_job(40, 3, 1'b1, 32767, 0, 32767, 1'b0);     // R3 saturated step
    run_job(60, 6, 1'b0, -32768, -32768, 5, 1'b0);   // R4 address wrap, R3
    run_job(5, 4, 1'b1, 0, 100, 100, 1'b0);          // R1 zero step
    run_job(33, 0, 1'b0, 256, 256, 256, 1'b0);       // R9 empty job
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        longint lv;
        longint gv;
        lv = (a == 0) ? 1 : (a == 1) ? 128 : (a == 2) ? 256 : 32767;
        gv = (b == 0) ? -32768 : (b == 1) ? -256 : (b == 2) ? 3 : 20000;
        run_job((a * 13 + b * 7) % DEPTH, 2, (a + b) % 2 == 1, lv, gv, gv, 1'b0);
      end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule